// File: doc/BRIEF.md
# Burst Write Sink and Read Bank Slave

This block is a memory-mapped AXI4 slave with a 32-bit data path. It takes incrementing write bursts from a processor interconnect and hands every accepted data beat to the write port of a downstream FIFO as a one-cycle push strobe with the beat's data. When the FIFO nears full, a busy input drives write-data ready low. Busy may rise and fall any number of times inside a burst, and every beat is still pushed exactly once.

The read side returns incrementing bursts from a 16-word register bank. The bank is loaded with a computed pattern at reset. The write and read channels are separate state machines, so an address on each channel in the same cycle is accepted at once and both bursts proceed in parallel. Transaction IDs are returned with each response. Response and read-data outputs hold steady under any amount of ready backpressure. No VALID output depends combinationally on the matching READY input.

Top module: `axiBurstSlave`

## Requirements
- R1: While rstN is low and at the first clock after it rises, awReady=1, arReady=1, wReady=0, bValid=0, rValid=0 and pushEn=0.
- R2: wReady is 0 in every cycle where fifoBusy is 1 or no write burst is open. Toggling fifoBusy inside a burst neither drops nor repeats a beat.
- R3: In each cycle with wValid=1 and wReady=1, pushEn=1 and pushData equals wData. A burst with awLen=N produces exactly N+1 pushes, in beat order, and no push happens in any other cycle.
- R4: wLast is taken into account only in a cycle where wValid and wReady are both 1. The burst closes on the handshake that carries wLast, or on beat awLen+1, whichever comes first.
- R5: In the cycle after the closing beat, bValid=1, bResp=2'b00 and bId holds the awId captured with the burst. Both stay unchanged until a cycle with bReady=1.
- R6: awReady is 0 from the cycle after an address is accepted until the cycle after the write-response handshake.
- R7: rId equals the captured arId on every beat. Beat k carries bank word ((arAddr>>2)+k) mod 16, where word i = 32'h1000_0000 + i*32'h0101_0101. rLast=1 only on beat arLen, and rResp=2'b00.
- R8: While rValid=1 and rReady=0, rValid, rData, rId and rLast hold their values into the next cycle.
- R9: When awValid and arValid arrive in the same cycle with both channels idle, both addresses are accepted on that edge, and both bursts complete with correct data and responses.
- R10: arReady is 0 while a read burst is being returned. It is 1 again in the cycle after the final beat's handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| awId | input | ID_W | Write burst ID |
| awLen | input | LEN_W | Write beats minus one |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address ready |
| wData | input | DATA_W | Write beat data |
| wLast | input | 1 | Final write beat marker |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data ready, low while busy |
| bId | output | ID_W | Write response ID |
| bResp | output | 2 | Write response code, always OKAY |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response ready |
| arId | input | ID_W | Read burst ID |
| arAddr | input | ADDR_W | Read start byte address |
| arLen | input | LEN_W | Read beats minus one |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address ready |
| rId | output | ID_W | Read data ID |
| rData | output | DATA_W | Read beat data |
| rResp | output | 2 | Read response code, always OKAY |
| rLast | output | 1 | Final read beat marker |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data ready |
| fifoBusy | input | 1 | Downstream almost-full indication |
| pushEn | output | 1 | FIFO push strobe |
| pushData | output | DATA_W | FIFO push word |

## Verification
A write counter that drifts from the true beat count shows up at the FIFO port within the same burst: the push stream is one word short or one word long, and bValid rises one beat early or late. An ID or data register that loses its value shows at the ports as a wrong bId on the response cycle, or a wrong rId or rData on the first stalled read beat. The stall checks compare the outputs in consecutive cycles. A state machine that leaves its idle state incorrectly blocks awReady or arReady, and the bench sees it one cycle after the handshake that should have freed the channel.

// File: rtl/axiBurstPkg.sv
package axiBurstPkg;

  typedef enum logic [1:0] {
    WR_IDLE  = 2'd0,
    WR_BEATS = 2'd1,
    WR_RESP  = 2'd2
  } wrStateT;

  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_SEND = 1'b1
  } rdStateT;

  // Per-cycle strobes from the control block to the datapath
  typedef struct packed {
    logic awTake;    // write address handshake
    logic wTake;     // write data handshake
    logic arTake;    // read address handshake
    logic rAdvance;  // read beat taken and more beats follow
  } ctrlStrobeT;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axiBurstCtrl.sv
module axiBurstCtrl
  import axiBurstPkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             awValid,
  input  logic [LEN_W-1:0] awLen,
  input  logic             wValid,
  input  logic             wLast,
  input  logic             bReady,
  input  logic             arValid,
  input  logic [LEN_W-1:0] arLen,
  input  logic             rReady,
  input  logic             fifoBusy,
  output logic             awReady,
  output logic             wReady,
  output logic             bValid,
  output logic             arReady,
  output logic             rValid,
  output logic             rLast,
  output ctrlStrobeT       strb
);

  wrStateT          wrState;
  rdStateT          rdState;
  logic [LEN_W-1:0] wrCnt;
  logic [LEN_W-1:0] wrLen;
  logic [LEN_W-1:0] rdCnt;
  logic [LEN_W-1:0] rdLen;
  logic             wrClose;
  logic             rdTake;

  // Ready and valid come from state only; wReady is also gated by busy
  assign awReady = (wrState == WR_IDLE);
  assign wReady  = (wrState == WR_BEATS) && !fifoBusy;
  assign bValid  = (wrState == WR_RESP);
  assign arReady = (rdState == RD_IDLE);
  assign rValid  = (rdState == RD_SEND);
  assign rLast   = rValid && (rdCnt == rdLen);

  assign rdTake  = rValid && rReady;

  always_comb begin
    strb          = '0;
    strb.awTake   = awValid && awReady;
    strb.wTake    = wValid && wReady;
    strb.arTake   = arValid && arReady;
    strb.rAdvance = rdTake && !rLast;
  end

  // wLast only counts on a real handshake
  assign wrClose = strb.wTake && (wLast || (wrCnt == wrLen));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrState <= WR_IDLE;
      wrCnt   <= '0;
      wrLen   <= '0;
    end else begin
      unique case (wrState)
        WR_IDLE: begin
          if (strb.awTake) begin
            wrState <= WR_BEATS;
            wrLen   <= awLen;
            wrCnt   <= '0;
          end
        end
        WR_BEATS: begin
          if (wrClose) begin
            wrState <= WR_RESP;
            wrCnt   <= '0;
          end else if (strb.wTake) begin
            wrCnt <= wrCnt + 1'b1;
          end
        end
        WR_RESP: begin
          if (bReady) wrState <= WR_IDLE;
        end
        default: wrState <= WR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdState <= RD_IDLE;
      rdCnt   <= '0;
      rdLen   <= '0;
    end else begin
      unique case (rdState)
        RD_IDLE: begin
          if (strb.arTake) begin
            rdState <= RD_SEND;
            rdLen   <= arLen;
            rdCnt   <= '0;
          end
        end
        RD_SEND: begin
          if (rdTake) begin
            if (rLast) begin
              rdState <= RD_IDLE;
              rdCnt   <= '0;
            end else begin
              rdCnt <= rdCnt + 1'b1;
            end
          end
        end
        default: rdState <= RD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/axiBurstData.sv
module axiBurstData
  import axiBurstPkg::*;
#(
  parameter int              ID_W      = 4,
  parameter int              ADDR_W    = 12,
  parameter int              DATA_W    = 32,
  parameter int              DEPTH     = 16,
  parameter logic [DATA_W-1:0] BANK_BASE = 32'h1000_0000,
  parameter logic [DATA_W-1:0] BANK_STEP = 32'h0101_0101
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strb,
  input  logic [ID_W-1:0]   awId,
  input  logic [DATA_W-1:0] wData,
  input  logic [ID_W-1:0]   arId,
  input  logic [ADDR_W-1:0] arAddr,
  output logic [ID_W-1:0]   bId,
  output logic [ID_W-1:0]   rId,
  output logic [DATA_W-1:0] rData,
  output logic              pushEn,
  output logic [DATA_W-1:0] pushData
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] bank [DEPTH];
  logic [IDX_W-1:0]  startIdx;
  logic [IDX_W-1:0]  nextIdx;

  // Word index from a 4-byte aligned byte address, wrapping in the bank
  assign startIdx = IDX_W'(arAddr >> 2);

  assign pushEn   = strb.wTake;
  assign pushData = wData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        bank[i] <= BANK_BASE + DATA_W'(i) * BANK_STEP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bId <= '0;
    end else if (strb.awTake) begin
      bId <= awId;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rId     <= '0;
      rData   <= '0;
      nextIdx <= '0;
    end else if (strb.arTake) begin
      rId     <= arId;
      rData   <= bank[startIdx];
      nextIdx <= startIdx + 1'b1;
    end else if (strb.rAdvance) begin
      rData   <= bank[nextIdx];
      nextIdx <= nextIdx + 1'b1;
    end
  end

endmodule

// File: rtl/axiBurstSlave.sv
module axiBurstSlave
  import axiBurstPkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   awId,
  input  logic [LEN_W-1:0]  awLen,
  input  logic              awValid,
  output logic              awReady,
  input  logic [DATA_W-1:0] wData,
  input  logic              wLast,
  input  logic              wValid,
  output logic              wReady,
  output logic [ID_W-1:0]   bId,
  output logic [1:0]        bResp,
  output logic              bValid,
  input  logic              bReady,
  input  logic [ID_W-1:0]   arId,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic [LEN_W-1:0]  arLen,
  input  logic              arValid,
  output logic              arReady,
  output logic [ID_W-1:0]   rId,
  output logic [DATA_W-1:0] rData,
  output logic [1:0]        rResp,
  output logic              rLast,
  output logic              rValid,
  input  logic              rReady,
  input  logic              fifoBusy,
  output logic              pushEn,
  output logic [DATA_W-1:0] pushData
);

  ctrlStrobeT strb;

  assign bResp = RESP_OKAY;
  assign rResp = RESP_OKAY;

  axiBurstCtrl #(
    .LEN_W (LEN_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .awValid  (awValid),
    .awLen    (awLen),
    .wValid   (wValid),
    .wLast    (wLast),
    .bReady   (bReady),
    .arValid  (arValid),
    .arLen    (arLen),
    .rReady   (rReady),
    .fifoBusy (fifoBusy),
    .awReady  (awReady),
    .wReady   (wReady),
    .bValid   (bValid),
    .arReady  (arReady),
    .rValid   (rValid),
    .rLast    (rLast),
    .strb     (strb)
  );

  axiBurstData #(
    .ID_W   (ID_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .awId     (awId),
    .wData    (wData),
    .arId     (arId),
    .arAddr   (arAddr),
    .bId      (bId),
    .rId      (rId),
    .rData    (rData),
    .pushEn   (pushEn),
    .pushData (pushData)
  );

endmodule

// File: rtl/axiBurstSlaveChk.sv
module axiBurstSlaveChk #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              awValid,
  input logic              awReady,
  input logic              wReady,
  input logic              bValid,
  input logic              bReady,
  input logic [ID_W-1:0]   bId,
  input logic [1:0]        bResp,
  input logic              arValid,
  input logic              arReady,
  input logic              rValid,
  input logic              rReady,
  input logic [ID_W-1:0]   rId,
  input logic [DATA_W-1:0] rData,
  input logic              rLast,
  input logic              fifoBusy,
  input logic              pushEn
);

  AST_BUSY_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rstN)
    fifoBusy |-> !wReady);  // R2

  AST_NO_PUSH_IN_RESP: assert property (@(posedge clk) disable iff (!rstN)
    bValid |-> !pushEn);  // R3

  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> (bValid && $stable(bId) && bResp == 2'b00));  // R5

  AST_AW_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && awReady) |=> !awReady);  // R6

  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> (rValid && $stable(rData) && $stable(rId) && $stable(rLast)));  // R8

  AST_BOTH_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && awReady && arValid && arReady) |=> (!awReady && !arReady));  // R9

  AST_AR_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> !arReady);  // R10

endmodule

bind axiBurstSlave axiBurstSlaveChk #(.ID_W(ID_W), .DATA_W(DATA_W)) uChk (.*);

// File: tb/tb_axiBurstSlave.sv
`timescale 1ns/1ps
module tb_axiBurstSlave;

  localparam int ID_W = 4, ADDR_W = 12, DATA_W = 32, LEN_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ID_W-1:0] awId = '0;
  logic [LEN_W-1:0] awLen = '0;
  logic awValid = 1'b0, awReady;
  logic [DATA_W-1:0] wData = '0;
  logic wLast = 1'b0, wValid = 1'b0, wReady;
  logic [ID_W-1:0] bId;
  logic [1:0] bResp;
  logic bValid, bReady = 1'b0;
  logic [ID_W-1:0] arId = '0;
  logic [ADDR_W-1:0] arAddr = '0;
  logic [LEN_W-1:0] arLen = '0;
  logic arValid = 1'b0, arReady;
  logic [ID_W-1:0] rId;
  logic [DATA_W-1:0] rData;
  logic [1:0] rResp;
  logic rLast, rValid, rReady = 1'b0;
  logic fifoBusy = 1'b0;
  logic pushEn;
  logic [DATA_W-1:0] pushData;

  int checks = 0, errors = 0;
  logic [DATA_W-1:0] expQ[$];
  logic [DATA_W-1:0] gotQ[$];
  int totalPush = 0, totalExp = 0;

  always #2.5 clk = ~clk;

  axiBurstSlave dut (.*);

  always @(posedge clk) if (pushEn) begin
    gotQ.push_back(pushData);
    totalPush++;
  end

  function automatic logic [31:0] bankWord(int i);
    return 32'h1000_0000 + 32'((i % 16)) * 32'h0101_0101;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(awReady && arReady && !wReady && !bValid && !rValid && !pushEn, "R1",
          "idle outputs in reset", {awReady, arReady, wReady, bValid, rValid, pushEn}, 32'h30);
    rstN = 1'b1;
    @(negedge clk);
    check(awReady && arReady && !wReady && !bValid && !rValid && !pushEn, "R1",
          "idle outputs after reset", {awReady, arReady, wReady, bValid, rValid, pushEn}, 32'h30);
  endtask

  // mode 0: no busy; mode 1: busy toggles, valid gaps, stray wLast on gaps
  task automatic doWrite(logic [ID_W-1:0] id, int len, int mode, int burstNo, int bStall);
    int beat = 0;
    int cyc = 0;
    logic [DATA_W-1:0] d;
    bit hs;
    expQ.delete();
    gotQ.delete();
    @(negedge clk);
    awId = id; awLen = LEN_W'(len - 1); awValid = 1'b1;
    while (!awReady) @(negedge clk);
    @(posedge clk);
    while (beat < len) begin
      @(negedge clk);
      awValid = 1'b0;
      fifoBusy = (mode == 1) && ((cyc % 7 == 2) || (cyc % 7 == 3) || (cyc % 11 == 5));
      wValid = !((mode == 1) && (cyc % 5 == 1));
      d = DATA_W'(burstNo * 256 + beat) ^ {id, 28'h0};
      wData = d;
      wLast = wValid ? (beat == len - 1) : (mode == 1);
      #1;
      if (fifoBusy) check(!wReady, "R2", "wReady while busy", 32'(wReady), 32'h0);
      hs = wValid && wReady;
      check(pushEn == hs, "R3", "push only on handshake", 32'(pushEn), 32'(hs));
      if (hs) begin
        expQ.push_back(d);
        totalExp++;
        beat++;
      end
      @(posedge clk);
      cyc++;
    end
    @(negedge clk);
    wValid = 1'b0; wLast = 1'b0; fifoBusy = 1'b0;
    check(gotQ.size() == expQ.size(), "R3", "push count", 32'(gotQ.size()), 32'(expQ.size()));
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      check(gotQ[i] == expQ[i], (mode == 1) ? "R2" : "R3", "pushed word", gotQ[i], expQ[i]);
    check(bValid && bResp == 2'b00 && bId == id, "R5", "response id/code",
          {bValid, 1'b0, bResp, bId}, {4'h8, id});
    check(!awReady, "R6", "awReady during response", 32'(awReady), 32'h0);
    for (int s = 0; s < bStall; s++) begin
      @(negedge clk);
      check(bValid && bId == id, "R5", "response held", {bValid, 3'b0, bId}, {4'h8, id});
      check(!awReady, "R6", "awReady while response held", 32'(awReady), 32'h0);
    end
    bReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bReady = 1'b0;
    check(!bValid && awReady, "R6", "channel freed", {bValid, awReady}, 32'h1);
  endtask

  task automatic doRead(logic [ID_W-1:0] id, logic [ADDR_W-1:0] addr, int len, bit stall);
    int k = 0;
    int cyc = 0;
    bit wasStalled = 1'b0;
    logic [DATA_W-1:0] pData = '0;
    logic [ID_W-1:0] pId = '0;
    logic pLast = 1'b0;
    int base;
    base = int'(addr >> 2);
    @(negedge clk);
    arId = id; arAddr = addr; arLen = LEN_W'(len - 1); arValid = 1'b1;
    while (!arReady) @(negedge clk);
    @(posedge clk);
    while (k < len) begin
      @(negedge clk);
      arValid = 1'b0;
      rReady = !(stall && (cyc % 3 != 2));
      #1;
      check(rValid && !arReady, "R10", "read busy", {rValid, arReady}, 32'h2);
      if (wasStalled)
        check(rValid && rData == pData && rId == pId && rLast == pLast, "R8",
              "held beat", rData, pData);
      check(rData == bankWord(base + k), "R7", "read word", rData, bankWord(base + k));
      check(rId == id && rResp == 2'b00, "R7", "read id/code", {rResp, rId}, {2'b00, id});
      check(rLast == (k == len - 1), "R7", "rLast position", 32'(rLast), 32'(k == len - 1));
      wasStalled = rValid && !rReady;
      pData = rData; pId = rId; pLast = rLast;
      @(posedge clk);
      if (rValid && rReady) k++;
      cyc++;
    end
    @(negedge clk);
    rReady = 1'b0;
    check(!rValid && arReady, "R10", "read channel freed", {rValid, arReady}, 32'h1);
  endtask

  task automatic testConcurrent();
    fork
      doWrite(4'h9, 16, 1, 200, 2);
      doRead(4'h6, 12'h01C, 16, 1'b1);
      begin
        @(negedge clk);
        #1;
        check(awValid && arValid && awReady && arReady, "R9", "both addresses offered",
              {awValid, arValid, awReady, arReady}, 32'hF);
        @(negedge clk);
        #1;
        check(!awReady && !arReady, "R9", "both addresses taken", {awReady, arReady}, 32'h0);
      end
    join
  endtask

  task automatic testWlastQualify();
    // Stray wLast with wValid low must not close a 4-beat burst early
    doWrite(4'h3, 4, 1, 250, 0);
    check(totalPush == totalExp, "R4", "stray wLast ignored", 32'(totalPush), 32'(totalExp));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    doWrite(4'h1, 4, 0, 1, 3);
    doWrite(4'hA, 16, 1, 2, 1);
    testWlastQualify();
    doRead(4'h5, 12'h000, 16, 1'b0);
    doRead(4'hC, 12'h038, 6, 1'b1);
    testConcurrent();
    // 1024-word stream: 32 bursts of 16, then 128 bursts of 4
    for (int b = 0; b < 32; b++) doWrite(4'(b), 16, b % 2, 10 + b, b % 3);
    for (int b = 0; b < 128; b++) doWrite(4'(b), 4, (b + 1) % 2, 60 + b, 0);
    check(totalPush == totalExp, "R3", "total pushes", 32'(totalPush), 32'(totalExp));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule